// File: doc/BRIEF.md
# Three-Output Clock-Enable Strobe Generator

This block stands in for a clock system inside a single-clock design. No clock is gated or divided for real. Three oscillator inputs each arrive as a one-cycle enable pulse in the system clock domain:

- a fast digitally controlled source;
- a low-frequency crystal;
- a very-low-power oscillator.

The block turns these pulses into three clock-enable strobes. The master strobe feeds the processor logic, the subsystem strobe feeds peripherals, and the auxiliary strobe feeds real-time logic. Each strobe has its own source select and its own power-of-two divider.

The crystal and the very-low-power oscillator share a single low-frequency slot, and a separate control field chooses which of the two fills it. Any output whose source select points at the low-frequency slot follows that choice. A crystal fault input sets a sticky fault flag. Software clears the flag by writing zero to its bit, but a fault in the same cycle wins.

Software programs the block through a write-only port. Address 0 is the master configuration, address 1 the subsystem configuration, address 2 the auxiliary configuration and address 3 the low-frequency control. A configuration write takes effect in the cycle after it is sampled.

Top module: `clkgen_strobes`

## Requirements
- R1: After synchronous reset all three strobes and the fault flag are low. Master and subsystem take the fast source divided by 1, and auxiliary takes the low-frequency slot divided by 1 with the crystal in that slot.
- R2: In a configuration word (addresses 0, 1, 2), bits [3:2] are the source select and bits [1:0] the divider code. Source values 0 and 1 pick the fast source, and values 2 and 3 pick the low-frequency slot.
- R3: Divider code d makes the strobe fire once per 2^d source pulses, so code 3 divides by 8.
- R4: A strobe rises in the cycle after the source pulse that completes a divided period and is high for exactly one system clock cycle. It never fires without such a pulse.
- R5: At address 3, bits [1:0] equal to 2 put the very-low-power oscillator in the low-frequency slot, and any other value puts the crystal there. Every output using the slot follows the new choice from the next cycle.
- R6: Writing an output's configuration word restarts that output's divider. A source pulse in the write cycle yields no strobe, and the next strobe comes after a full period at the new setting.
- R7: A high fault input sets the fault flag in the next cycle, and the flag stays set while no clear is requested.
- R8: A write to address 3 with bit 7 equal to 0 clears the fault flag, and a write with bit 7 equal to 1 leaves it unchanged.
- R9: A fault in the same cycle as a clear write leaves the flag set.
- R10: Changing the low-frequency slot between crystal and very-low-power oscillator restarts the dividers of the outputs that use the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dco_tick | input | 1 | Fast oscillator enable pulse |
| xtal_tick | input | 1 | Low-frequency crystal enable pulse |
| vlp_tick | input | 1 | Very-low-power oscillator enable pulse |
| xtal_fault | input | 1 | Crystal fault indication |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| mst_stb | output | 1 | Master clock-enable strobe |
| sub_stb | output | 1 | Subsystem clock-enable strobe |
| aux_stb | output | 1 | Auxiliary clock-enable strobe |
| osc_fault | output | 1 | Sticky crystal fault flag |

## Verification
Two functions can meet in the same cycle. The first case is a fault arriving while software writes a clear to the fault bit. The second is a configuration write, or a slot change, landing on the cycle of a source pulse that would complete a divided period. The bench drives both cases deliberately: it raises the fault on the clear write, and it writes configurations in the middle of continuous fast pulses and in the middle of crystal-paced counting. Each result is judged against a cycle-level model of the requirements. The flag must stay high in the first case, and no strobe may appear in the restart cycle in the second.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int N_OUT  = 3;
    localparam int SRC_W  = 2;
    localparam int DIV_W  = 2;
    localparam int CNT_W  = (1 << DIV_W) - 1;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int FLAG_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] ADDR_LF    = 2'd3;
    localparam logic [1:0]        LF_CODE_VLP = 2'd2;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } out_cfg_t;

    // auxiliary output (index 2) defaults to the low-frequency slot
    function automatic out_cfg_t cfg_default(input int idx);
        out_cfg_t c;
        c.src = (idx == 2) ? SRC_W'(3) : SRC_W'(0);
        c.div = '0;
        return c;
    endfunction

    function automatic logic src_is_lf(input logic [SRC_W-1:0] src);
        return src[SRC_W-1];
    endfunction

endpackage

// File: rtl/clkgen_divider.sv
module clkgen_divider #(
    parameter int DIV_W = 2,
    localparam int CNT_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_code,
    output logic             stb
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim = CNT_W'((1 << div_code) - 1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
            stb <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (tick) begin
                if (cnt == lim) begin
                    cnt <= '0;
                    stb <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_restart_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        restart |=> !stb);

    p_stb_needs_tick_r4: assert property (@(posedge clk) disable iff (rst)
        stb |-> $past(tick));

    p_gap_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (stb && div_code != '0) |=> !stb);

endmodule

// File: rtl/clkgen_fault_flag.sv
module clkgen_fault_flag (
    input  logic clk,
    input  logic rst,
    input  logic fault_in,
    input  logic clear_req,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= fault_in | (flag & ~clear_req);
    end

    p_fault_sets_r7: assert property (@(posedge clk) disable iff (rst)
        fault_in |=> flag);

    p_fault_beats_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_in && clear_req) |=> flag);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clear_req) |=> flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clear_req && !fault_in) |=> !flag);

endmodule

// File: rtl/clkgen_strobes.sv
module clkgen_strobes
    import clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dco_tick,
    input  logic              xtal_tick,
    input  logic              vlp_tick,
    input  logic              xtal_fault,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              mst_stb,
    output logic              sub_stb,
    output logic              aux_stb,
    output logic              osc_fault
);

    logic             lf_vlp_q;
    logic             lf_tick;
    logic             lf_wr;
    logic             lf_wr_vlp;
    logic             lf_changed;
    logic [N_OUT-1:0] stb_vec;
    logic             unused_wdata;

    assign unused_wdata = ^cfg_wdata[FLAG_BIT-1:SRC_W+DIV_W];

    // low-frequency slot: crystal or very-low-power oscillator
    assign lf_tick    = lf_vlp_q ? vlp_tick : xtal_tick;
    assign lf_wr      = cfg_we && (cfg_addr == ADDR_LF);
    assign lf_wr_vlp  = (cfg_wdata[1:0] == LF_CODE_VLP);
    assign lf_changed = lf_wr && (lf_wr_vlp != lf_vlp_q);

    always_ff @(posedge clk) begin
        if (rst)        lf_vlp_q <= 1'b0;
        else if (lf_wr) lf_vlp_q <= lf_wr_vlp;
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        out_cfg_t cfg_q;
        logic     wr_hit;
        logic     src_lf;
        logic     restart;
        logic     tick;

        assign wr_hit  = cfg_we && (cfg_addr == ADDR_W'(g));
        assign src_lf  = src_is_lf(cfg_q.src);
        assign restart = wr_hit || (lf_changed && src_lf);
        assign tick    = src_lf ? lf_tick : dco_tick;

        always_ff @(posedge clk) begin
            if (rst)         cfg_q <= cfg_default(g);
            else if (wr_hit) cfg_q <= out_cfg_t'(cfg_wdata[SRC_W+DIV_W-1:0]);
        end

        clkgen_divider #(.DIV_W(DIV_W)) u_div (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .restart  (restart),
            .div_code (cfg_q.div),
            .stb      (stb_vec[g])
        );
    end

    clkgen_fault_flag u_fault (
        .clk       (clk),
        .rst       (rst),
        .fault_in  (xtal_fault),
        .clear_req (lf_wr && !cfg_wdata[FLAG_BIT]),
        .flag      (osc_fault)
    );

    assign mst_stb = stb_vec[0];
    assign sub_stb = stb_vec[1];
    assign aux_stb = stb_vec[2];

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (stb_vec == '0 && !osc_fault));

    p_lf_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (lf_changed && src_is_lf(g_out[2].cfg_q.src)) |=> !aux_stb);

endmodule

// File: tb/sim_clkgen_strobes.sv
module sim_clkgen_strobes;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dco_tick = 1'b0, xtal_tick = 1'b0, vlp_tick = 1'b0;
    logic       xtal_fault = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       mst_stb, sub_stb, aux_stb, osc_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_strobes u0 (
        .clk(clk), .rst(rst), .dco_tick(dco_tick), .xtal_tick(xtal_tick),
        .vlp_tick(vlp_tick), .xtal_fault(xtal_fault), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mst_stb(mst_stb),
        .sub_stb(sub_stb), .aux_stb(aux_stb), .osc_fault(osc_fault)
    );

    typedef struct {
        logic [3:0] exp;   // {flag, aux, sub, master}
        string      tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // reference model state
    int m_src[3];
    int m_div[3];
    int m_cnt[3];
    bit m_vlp;
    bit m_flag;

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; dco_tick = 0; xtal_tick = 0; vlp_tick = 0;
        xtal_fault = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
        for (int i = 0; i < 3; i++) begin
            m_src[i] = (i == 2) ? 3 : 0;
            m_div[i] = 0;
            m_cnt[i] = 0;
        end
        m_vlp = 0; m_flag = 0;
        sb.push_back('{4'b0000, "R1"});
    endtask

    task automatic step(input bit ef, input bit ex, input bit ev, input bit flt,
                        input bit we, input logic [1:0] a, input logic [7:0] d,
                        input string tag);
        logic [3:0] e;
        bit new_vlp, lfchg, lf, tk, rs;
        int lim;
        @(negedge clk);
        rst = 0; dco_tick = ef; xtal_tick = ex; vlp_tick = ev;
        xtal_fault = flt; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        new_vlp = (we && a == 2'd3) ? (d[1:0] == 2'd2) : m_vlp;
        lfchg   = we && a == 2'd3 && (new_vlp != m_vlp);
        e = '0;
        for (int i = 0; i < 3; i++) begin
            lf  = (m_src[i] >= 2);
            tk  = lf ? (m_vlp ? ev : ex) : ef;
            rs  = (we && a == i[1:0]) || (lfchg && lf);
            lim = (1 << m_div[i]) - 1;
            if (rs) m_cnt[i] = 0;
            else if (tk) begin
                if (m_cnt[i] == lim) begin e[i] = 1'b1; m_cnt[i] = 0; end
                else m_cnt[i]++;
            end
        end
        if (we && a != 2'd3) begin
            m_src[a] = int'(d[3:2]);
            m_div[a] = int'(d[1:0]);
        end
        m_vlp  = new_vlp;
        m_flag = flt | (m_flag & !(we && a == 2'd3 && !d[7]));
        e[3]   = m_flag;
        sb.push_back('{e, tag});
    endtask

    task automatic idle(input int n, input bit ef, input int xmod, input int vmod,
                        input string tag);
        for (int i = 0; i < n; i++)
            step(ef, (i % xmod) == 0, (i % vmod) == 0, 0, 0, 2'd0, 8'h00, tag);
    endtask

    // monitor: compare each produced cycle against the queue head
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                logic [3:0] got;
                it  = sb.pop_front();
                got = {osc_fault, aux_stb, sub_stb, mst_stb};
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: {flag,aux,sub,mst} actual=%b expected=%b at %0t",
                             it.tag, got, it.exp, $time);
                end
            end
        end
    end

    initial begin
        do_reset();
        // R1: defaults, master/sub follow fast pulses, aux follows crystal
        idle(10, 1, 2, 1, "R1");
        // R3: master divide by 8, subsystem divide by 2
        step(1, 0, 0, 0, 1, 2'd0, 8'h03, "R3");
        idle(24, 1, 3, 1, "R3");
        step(1, 0, 0, 0, 1, 2'd1, 8'h01, "R3");
        idle(12, 1, 3, 1, "R3");
        // R6: rewrite master mid-count while fast pulses run
        idle(3, 1, 3, 1, "R6");
        step(1, 1, 0, 0, 1, 2'd0, 8'h02, "R6");
        idle(10, 1, 3, 1, "R6");
        step(1, 1, 0, 0, 1, 2'd0, 8'h00, "R6");
        idle(3, 1, 3, 1, "R6");
        // R2: subsystem onto the low-frequency slot, master via code 1
        step(1, 0, 0, 0, 1, 2'd1, 8'h08, "R2");
        step(1, 0, 0, 0, 1, 2'd0, 8'h05, "R2");
        idle(12, 1, 3, 2, "R2");
        // R10: aux at divide by 4 on crystal, then switch the slot mid-count
        step(0, 0, 0, 0, 1, 2'd2, 8'h0E, "R10");
        idle(6, 0, 1, 1, "R10");
        step(0, 1, 1, 0, 1, 2'd3, 8'h82, "R10");
        // R5: very-low-power oscillator now paces the slot; crystal ignored
        idle(16, 1, 1, 3, "R5");
        step(0, 1, 0, 0, 1, 2'd3, 8'h81, "R5");
        idle(12, 0, 2, 1, "R5");
        // R7: fault sets and sticks
        step(0, 0, 0, 1, 0, 2'd0, 8'h00, "R7");
        idle(5, 0, 4, 4, "R7");
        // R8: bit 7 set does not clear
        step(0, 0, 0, 0, 1, 2'd3, 8'h80, "R8");
        idle(2, 0, 4, 4, "R8");
        // R9: fault on the clear cycle wins
        step(0, 0, 0, 1, 1, 2'd3, 8'h00, "R9");
        idle(2, 0, 4, 4, "R9");
        // R8: clear without fault
        step(0, 0, 0, 0, 1, 2'd3, 8'h00, "R8");
        idle(3, 0, 4, 4, "R8");
        // R4: mixed pulse patterns across divider settings
        step(0, 0, 0, 0, 1, 2'd1, 8'h0A, "R4");
        step(0, 0, 0, 0, 1, 2'd0, 8'h01, "R4");
        for (int i = 0; i < 80; i++)
            step((i % 5) != 0, (i % 4) == 0, (i % 3) == 0, 0,
                 (i % 29) == 28, 2'd2, 8'(8'h0C + (i % 4)), "R4");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL timeout (all requirements): actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule